// File: doc/BRIEF.md
# Memory Access Buffer with Address Ordering

This block sits on the memory side of an out-of-order core. It holds in-flight loads and stores in two small pools of buffers. Each buffer keeps the effective address of its access. A store buffer also keeps the value to write, or, while that value is still being computed, the tag of the unit that will produce it. The store picks that value off the shared result bus when the tag appears. The memory behind the block is a small synchronous word array that accepts one access per cycle.

When an access is accepted, its address is compared against every access already held. It records which older entries it must wait for. A load waits for older stores to the same word. A store waits for every older access to the same word. Accesses with no such dependence go to memory as soon as they are ready, in any order relative to program order. When several are ready, the oldest is served first. A load's word is driven onto the load result outputs together with the load's own tag, and the buffer is released in the same cycle.

Top module: `lsq_disamb`

## Requirements
- R1: `issue_ready` is high exactly when a buffer of the requested kind (`issue_is_store`) is free. An access offered while `issue_ready` is low is not accepted and has no effect on memory.
- R2: An accepted load returns `issue_tag` = LD_TAG_BASE (8) plus the index of the lowest free load buffer. An accepted store returns tag 0.
- R3: A load reads the memory word at its address and presents it on `ld_out_data`, with `ld_out_valid` high and `ld_out_tag` equal to its issue tag, for one cycle. Memory reads as zero after reset.
- R4: A store whose data is present at issue (`issue_data_ok`=1) writes `issue_data` to its address. A later load of that address returns that value.
- R5: A store issued with `issue_data_ok`=0 waits until `rb_valid` is high with `rb_tag` equal to its `issue_src_tag`, and then writes `rb_data`. A broadcast in the same cycle as the issue is also captured.
- R6: A load to the same address as an older pending store is not performed until that store has written memory, so the load returns the store's value.
- R7: A load whose address matches no older pending store proceeds even while an older store to another address is still waiting for data.
- R8: A store to the same address as an older pending load does not write until that load has read memory, so the load returns the old value.
- R9: Two stores to the same address write memory in program order, even when the younger store's data is ready first.
- R10: At most one memory access is made per cycle. Among ready accesses with no outstanding dependence, the oldest is served first.
- R11: During and right after reset, `ld_out_valid` is low and `issue_ready` is high for both kinds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | New memory access offered |
| issue_is_store | input | 1 | 1 = store, 0 = load |
| issue_addr | input | 4 | Effective word address |
| issue_data | input | 16 | Store value when present |
| issue_data_ok | input | 1 | Store value is present in `issue_data` |
| issue_src_tag | input | 4 | Producer tag of a missing store value |
| issue_ready | output | 1 | A buffer of the requested kind is free |
| issue_tag | output | 4 | Tag given to an accepted load (0 for stores) |
| rb_valid | input | 1 | Result bus carries a value |
| rb_tag | input | 4 | Producer tag on the result bus |
| rb_data | input | 16 | Value on the result bus |
| ld_out_valid | output | 1 | Load result is valid |
| ld_out_tag | output | 4 | Tag of the returning load |
| ld_out_data | output | 16 | Word read for the load |

## Verification
A missing or wrongly cleared dependence bit changes a value at the ports. A load then returns a word that is one store too old or too new, or the final contents of an address differ after two stores race. These errors show up in the next load of that address, a few cycles after the release. A bad age relation shows up in the order of load results on the result outputs. A lost data capture shows up as a load that never returns because it is stuck behind its store. A bad free-slot count shows up at once on `issue_ready` or `issue_tag`.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 16;
    localparam int TAG_W  = 4;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [TAG_W-1:0]  tag_t;

    // one buffer slot; loads keep data_ok at 1 for their whole life
    typedef struct packed {
        logic  busy;
        logic  sent;
        logic  data_ok;
        addr_t addr;
        tag_t  qi;
        data_t data;
    } lsq_entry_t;

    // a pair of accesses must stay ordered when they hit the same word
    // and at least one of them writes it
    function automatic logic must_order(input logic a_st, input logic b_st,
                                        input addr_t a_addr, input addr_t b_addr);
        return (a_addr == b_addr) && (a_st || b_st);
    endfunction

endpackage

// File: rtl/lsq_first_free.sv
module lsq_first_free #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  busy,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/lsq_order.sv
module lsq_order
    import lsq_pkg::*;
#(
    parameter int N = 8,
    localparam int IW = $clog2(N)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                alloc_en,
    input  logic [IW-1:0]       alloc_idx,
    input  logic                alloc_st,
    input  addr_t               alloc_addr,
    input  logic [N-1:0]        st_vec,
    input  addr_t [N-1:0]       addr_vec,
    input  logic [N-1:0]        busy_vec,
    input  logic [N-1:0]        free_vec,
    input  logic [N-1:0]        ready_vec,
    output logic [N-1:0]        grant_vec
);
    // older[i][j]: entry j was already live when entry i was accepted
    // dep[i][j]  : entry i must wait for entry j to leave
    logic [N-1:0] older [N];
    logic [N-1:0] dep   [N];
    logic [N-1:0] live;
    logic [N-1:0] new_older;
    logic [N-1:0] new_dep;
    logic [N-1:0] elig;

    assign live = busy_vec & ~free_vec;

    always_comb begin
        for (int j = 0; j < N; j++) begin
            new_older[j] = live[j];
            new_dep[j]   = live[j] && must_order(alloc_st, st_vec[j], alloc_addr, addr_vec[j]);
        end
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            elig[i] = ready_vec[i] && (dep[i] == '0);
        end
        for (int i = 0; i < N; i++) begin
            grant_vec[i] = elig[i] && ((elig & older[i]) == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                older[i] <= '0;
                dep[i]   <= '0;
            end
        end else begin
            for (int i = 0; i < N; i++) begin
                for (int j = 0; j < N; j++) begin
                    if (free_vec[j]) begin
                        older[i][j] <= 1'b0;
                        dep[i][j]   <= 1'b0;
                    end
                end
            end
            if (alloc_en) begin
                older[alloc_idx] <= new_older;
                dep[alloc_idx]   <= new_dep;
            end
        end
    end
endmodule

// File: rtl/lsq_mem.sv
module lsq_mem
    import lsq_pkg::*;
#(
    parameter int DEPTH = 2 ** ADDR_W
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  addr_t waddr,
    input  data_t wdata,
    input  logic  re,
    input  addr_t raddr,
    output data_t rdata
);
    data_t cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
            rdata <= '0;
        end else begin
            if (we) cells[waddr] <= wdata;
            if (re) rdata <= cells[raddr];
        end
    end
endmodule

// File: rtl/lsq_disamb.sv
module lsq_disamb
    import lsq_pkg::*;
#(
    parameter int NUM_LD      = 4,
    parameter int NUM_ST      = 4,
    parameter int LD_TAG_BASE = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                issue_valid,
    input  logic                issue_is_store,
    input  logic [ADDR_W-1:0]   issue_addr,
    input  logic [DATA_W-1:0]   issue_data,
    input  logic                issue_data_ok,
    input  logic [TAG_W-1:0]    issue_src_tag,
    output logic                issue_ready,
    output logic [TAG_W-1:0]    issue_tag,
    input  logic                rb_valid,
    input  logic [TAG_W-1:0]    rb_tag,
    input  logic [DATA_W-1:0]   rb_data,
    output logic                ld_out_valid,
    output logic [TAG_W-1:0]    ld_out_tag,
    output logic [DATA_W-1:0]   ld_out_data
);
    localparam int N   = NUM_LD + NUM_ST;
    localparam int EIW = $clog2(N);
    localparam int LIW = (NUM_LD > 1) ? $clog2(NUM_LD) : 1;
    localparam int SIW = (NUM_ST > 1) ? $clog2(NUM_ST) : 1;
    localparam logic [N-1:0] ST_MASK = {{NUM_ST{1'b1}}, {NUM_LD{1'b0}}};

    lsq_entry_t ent [N];

    logic [N-1:0]   busy_vec;
    logic [N-1:0]   ready_vec;
    logic [N-1:0]   free_vec;
    logic [N-1:0]   grant_vec;
    addr_t [N-1:0]  addr_vec;

    logic           ld_found, st_found;
    logic [LIW-1:0] ld_free_idx;
    logic [SIW-1:0] st_free_idx;
    logic           alloc_en;
    logic [EIW-1:0] alloc_idx;
    logic           cap_now;

    logic           gnt_any;
    logic [EIW-1:0] gnt_idx;
    logic           mem_we, mem_re;
    data_t          mem_rdata;
    logic           rd_v_q;
    logic [EIW-1:0] rd_idx_q;

    // ---------------- slot state as flat vectors ----------------
    always_comb begin
        for (int i = 0; i < N; i++) begin
            busy_vec[i]  = ent[i].busy;
            addr_vec[i]  = ent[i].addr;
            ready_vec[i] = ent[i].busy && !ent[i].sent && ent[i].data_ok;
        end
    end

    // ---------------- allocation ----------------
    lsq_first_free #(.N(NUM_LD)) u_ld_free (
        .busy  (busy_vec[NUM_LD-1:0]),
        .found (ld_found),
        .idx   (ld_free_idx)
    );

    lsq_first_free #(.N(NUM_ST)) u_st_free (
        .busy  (busy_vec[N-1:NUM_LD]),
        .found (st_found),
        .idx   (st_free_idx)
    );

    assign issue_ready = issue_is_store ? st_found : ld_found;
    assign alloc_en    = issue_valid && issue_ready;
    assign alloc_idx   = issue_is_store ? EIW'(NUM_LD + int'(st_free_idx)) : EIW'(ld_free_idx);
    assign issue_tag   = issue_is_store ? '0 : tag_t'(LD_TAG_BASE + int'(ld_free_idx));
    assign cap_now     = rb_valid && (rb_tag == issue_src_tag);

    // ---------------- ordering and selection ----------------
    lsq_order #(.N(N)) u_order (
        .clk        (clk),
        .rst        (rst),
        .alloc_en   (alloc_en),
        .alloc_idx  (alloc_idx),
        .alloc_st   (issue_is_store),
        .alloc_addr (issue_addr),
        .st_vec     (ST_MASK),
        .addr_vec   (addr_vec),
        .busy_vec   (busy_vec),
        .free_vec   (free_vec),
        .ready_vec  (ready_vec),
        .grant_vec  (grant_vec)
    );

    always_comb begin
        gnt_any = 1'b0;
        gnt_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (grant_vec[i]) begin
                gnt_any = 1'b1;
                gnt_idx = EIW'(i);
            end
        end
    end

    assign mem_we = gnt_any && ST_MASK[gnt_idx];
    assign mem_re = gnt_any && !ST_MASK[gnt_idx];

    // stores leave on their write, loads leave on their broadcast
    always_comb begin
        for (int i = 0; i < N; i++) begin
            free_vec[i] = (grant_vec[i] && ST_MASK[i]) ||
                          (rd_v_q && (rd_idx_q == EIW'(i)));
        end
    end

    // ---------------- memory ----------------
    lsq_mem u_mem (
        .clk   (clk),
        .rst   (rst),
        .we    (mem_we),
        .waddr (ent[gnt_idx].addr),
        .wdata (ent[gnt_idx].data),
        .re    (mem_re),
        .raddr (ent[gnt_idx].addr),
        .rdata (mem_rdata)
    );

    assign ld_out_valid = rd_v_q;
    assign ld_out_tag   = tag_t'(LD_TAG_BASE + int'(rd_idx_q));
    assign ld_out_data  = mem_rdata;

    // ---------------- slot updates ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) ent[i] <= '0;
            rd_v_q   <= 1'b0;
            rd_idx_q <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (ent[i].busy && !ent[i].data_ok && rb_valid && (rb_tag == ent[i].qi)) begin
                    ent[i].data_ok <= 1'b1;
                    ent[i].data    <= rb_data;
                end
                if (grant_vec[i]) ent[i].sent <= 1'b1;
                if (free_vec[i])  ent[i].busy <= 1'b0;
            end
            if (alloc_en) begin
                ent[alloc_idx].busy    <= 1'b1;
                ent[alloc_idx].sent    <= 1'b0;
                ent[alloc_idx].addr    <= issue_addr;
                ent[alloc_idx].qi      <= issue_src_tag;
                ent[alloc_idx].data_ok <= !issue_is_store || issue_data_ok || cap_now;
                ent[alloc_idx].data    <= issue_data_ok ? issue_data : rb_data;
            end
            rd_v_q   <= mem_re;
            rd_idx_q <= gnt_idx;
        end
    end
endmodule

// File: rtl/lsq_disamb_chk.sv
module lsq_disamb_chk
    import lsq_pkg::*;
#(
    parameter int NUM_LD      = 4,
    parameter int NUM_ST      = 4,
    parameter int LD_TAG_BASE = 8,
    localparam int N = NUM_LD + NUM_ST
) (
    input logic         clk,
    input logic         rst,
    input logic         issue_is_store,
    input logic         issue_ready,
    input logic         ld_out_valid,
    input tag_t         ld_out_tag,
    input logic [N-1:0] grant_vec,
    input logic [N-1:0] busy_vec,
    input logic         mem_we,
    input logic         mem_re
);
    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_vec)); // R10

    AST_MEM_SINGLE: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re)); // R10

    AST_LD_OUT_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        ld_out_valid |-> $past(mem_re)); // R3

    AST_LD_TAG_RANGE: assert property (@(posedge clk) disable iff (rst)
        ld_out_valid |-> (int'(ld_out_tag) >= LD_TAG_BASE && int'(ld_out_tag) < LD_TAG_BASE + NUM_LD)); // R2

    AST_LD_STALL_FULL: assert property (@(posedge clk) disable iff (rst)
        (!issue_is_store && !issue_ready) |-> (busy_vec[NUM_LD-1:0] == '1)); // R1

    AST_ST_STALL_FULL: assert property (@(posedge clk) disable iff (rst)
        (issue_is_store && !issue_ready) |-> (busy_vec[N-1:NUM_LD] == '1)); // R1

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> !ld_out_valid); // R11
endmodule

bind lsq_disamb lsq_disamb_chk #(
    .NUM_LD      (NUM_LD),
    .NUM_ST      (NUM_ST),
    .LD_TAG_BASE (LD_TAG_BASE)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .issue_is_store (issue_is_store),
    .issue_ready    (issue_ready),
    .ld_out_valid   (ld_out_valid),
    .ld_out_tag     (ld_out_tag),
    .grant_vec      (grant_vec),
    .busy_vec       (busy_vec),
    .mem_we         (mem_we),
    .mem_re         (mem_re)
);

// File: tb/test_lsq_disamb.sv
`timescale 1ns/1ps
module test_lsq_disamb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue_valid = 1'b0;
    logic        issue_is_store = 1'b0;
    logic [3:0]  issue_addr = '0;
    logic [15:0] issue_data = '0;
    logic        issue_data_ok = 1'b0;
    logic [3:0]  issue_src_tag = '0;
    logic        issue_ready;
    logic [3:0]  issue_tag;
    logic        rb_valid = 1'b0;
    logic [3:0]  rb_tag = '0;
    logic [15:0] rb_data = '0;
    logic        ld_out_valid;
    logic [3:0]  ld_out_tag;
    logic [15:0] ld_out_data;

    int tests = 0;
    int fails = 0;
    int log_n = 0;
    int log_tag  [64];
    int log_data [64];

    always #2 clk = ~clk;

    lsq_disamb i_lsq_disamb (
        .clk(clk), .rst(rst),
        .issue_valid(issue_valid), .issue_is_store(issue_is_store),
        .issue_addr(issue_addr), .issue_data(issue_data),
        .issue_data_ok(issue_data_ok), .issue_src_tag(issue_src_tag),
        .issue_ready(issue_ready), .issue_tag(issue_tag),
        .rb_valid(rb_valid), .rb_tag(rb_tag), .rb_data(rb_data),
        .ld_out_valid(ld_out_valid), .ld_out_tag(ld_out_tag), .ld_out_data(ld_out_data)
    );

    always @(negedge clk) begin
        if (!rst && ld_out_valid && log_n < 64) begin
            log_tag[log_n]  = int'(ld_out_tag);
            log_data[log_n] = int'(ld_out_data);
            log_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // one issue attempt held for exactly one rising edge
    task automatic issue(input bit st, input int addr, input bit dok, input int data,
                         input int src, output int tag);
        @(negedge clk);
        issue_valid    = 1'b1;
        issue_is_store = st;
        issue_addr     = 4'(addr);
        issue_data_ok  = dok;
        issue_data     = 16'(data);
        issue_src_tag  = 4'(src);
        #0.5;
        tag = int'(issue_tag);
        @(posedge clk);
        #0.5;
        issue_valid = 1'b0;
    endtask

    task automatic bcast(input int tag, input int data);
        @(negedge clk);
        rb_valid = 1'b1;
        rb_tag   = 4'(tag);
        rb_data  = 16'(data);
        @(posedge clk);
        #0.5;
        rb_valid = 1'b0;
    endtask

    task automatic find(input int from, input int tag, output int pos, output int data);
        pos = -1;
        data = -1;
        for (int i = from; i < log_n; i++) begin
            if (log_tag[i] == tag && pos < 0) begin
                pos = i;
                data = log_data[i];
            end
        end
    endtask

    task automatic expect_load(input int from, input int tag, input int exp, input string req);
        int p, d;
        find(from, tag, p, d);
        chk(p >= 0 && d == exp, req, d, exp);
    endtask

    task automatic t_reset;
        @(negedge clk);
        issue_is_store = 1'b0;
        #0.5;
        chk(issue_ready === 1'b1, "R11 load ready", int'(issue_ready), 1);
        chk(ld_out_valid === 1'b0, "R11 no load result", int'(ld_out_valid), 0);
        issue_is_store = 1'b1;
        #0.5;
        chk(issue_ready === 1'b1, "R11 store ready", int'(issue_ready), 1);
    endtask

    task automatic t_store_then_load;
        int s, a, b, base;
        base = log_n;
        issue(1'b1, 3, 1'b1, 'h1234, 0, s);
        chk(s == 0, "R2 store tag", s, 0);
        idle(3);
        issue(1'b0, 3, 1'b1, 0, 0, a);
        chk(a == 8, "R2 first load tag", a, 8);
        issue(1'b0, 9, 1'b1, 0, 0, b);
        chk(b == 9, "R2 second load tag", b, 9);
        idle(6);
        expect_load(base, a, 'h1234, "R4 load sees stored word");
        expect_load(base, b, 0, "R3 untouched word reads zero");
    endtask

    task automatic t_wait_and_bypass;
        int s, a, b, pa, pb, d, base;
        base = log_n;
        issue(1'b1, 5, 1'b0, 0, 3, s);
        issue(1'b0, 5, 1'b1, 0, 0, a);
        issue(1'b0, 6, 1'b1, 0, 0, b);
        idle(6);
        find(base, b, pb, d);
        chk(pb >= 0 && d == 0, "R7 unrelated load proceeds", d, 0);
        find(base, a, pa, d);
        chk(pa < 0, "R6 dependent load held", pa, -1);
        bcast(3, 'hBEEF);
        idle(6);
        expect_load(base, a, 'hBEEF, "R6 load returns store value");
        expect_load(base, a, 'hBEEF, "R5 store captured bus value");
    endtask

    task automatic t_same_cycle_capture;
        int s, a, base;
        base = log_n;
        @(negedge clk);
        rb_valid = 1'b1;
        rb_tag   = 4'd5;
        rb_data  = 16'h0777;
        issue_valid    = 1'b1;
        issue_is_store = 1'b1;
        issue_addr     = 4'd7;
        issue_data_ok  = 1'b0;
        issue_data     = 16'h0;
        issue_src_tag  = 4'd5;
        @(posedge clk);
        #0.5;
        issue_valid = 1'b0;
        rb_valid    = 1'b0;
        idle(2);
        issue(1'b0, 7, 1'b1, 0, 0, a);
        idle(6);
        expect_load(base, a, 'h0777, "R5 capture in issue cycle");
        s = 0;
    endtask

    task automatic t_load_before_store;
        int s, a, c, base;
        base = log_n;
        issue(1'b0, 10, 1'b1, 0, 0, a);
        issue(1'b1, 10, 1'b1, 'hAAAA, 0, s);
        idle(5);
        expect_load(base, a, 0, "R8 older load keeps old word");
        issue(1'b0, 10, 1'b1, 0, 0, c);
        idle(6);
        expect_load(base + 1, c, 'hAAAA, "R8 store lands afterwards");
    endtask

    task automatic t_store_store;
        int s, a, base;
        base = log_n;
        issue(1'b1, 11, 1'b0, 0, 4, s);
        issue(1'b1, 11, 1'b1, 'h2222, 0, s);
        idle(4);
        bcast(4, 'h1111);
        idle(6);
        issue(1'b0, 11, 1'b1, 0, 0, a);
        idle(6);
        expect_load(base, a, 'h2222, "R9 younger store wins");
    endtask

    task automatic t_full;
        int s, tg [4], base;
        base = log_n;
        for (int i = 0; i < 4; i++) issue(1'b1, 12 + i, 1'b0, 0, 6, s);
        @(negedge clk);
        issue_is_store = 1'b1;
        #0.5;
        chk(issue_ready === 1'b0, "R1 store pool full", int'(issue_ready), 0);
        issue_is_store = 1'b0;
        #0.5;
        chk(issue_ready === 1'b1, "R1 load pool free", int'(issue_ready), 1);
        issue(1'b1, 12, 1'b1, 'hDEAD, 0, s);
        for (int i = 0; i < 4; i++) issue(1'b0, 12 + i, 1'b1, 0, 0, tg[i]);
        @(negedge clk);
        issue_is_store = 1'b0;
        #0.5;
        chk(issue_ready === 1'b0, "R1 load pool full", int'(issue_ready), 0);
        bcast(6, 'h6666);
        idle(20);
        expect_load(base, tg[0], 'h6666, "R1 refused store had no effect");
        expect_load(base, tg[3], 'h6666, "R6 load after released store");
    endtask

    task automatic t_oldest_first;
        int s, a, b, pa, pb, da, db, base;
        base = log_n;
        issue(1'b1, 4, 1'b0, 0, 2, s);
        issue(1'b1, 2, 1'b0, 0, 2, s);
        issue(1'b0, 4, 1'b1, 0, 0, a);
        issue(1'b0, 2, 1'b1, 0, 0, b);
        idle(2);
        bcast(2, 'h0C0C);
        idle(10);
        find(base, a, pa, da);
        find(base, b, pb, db);
        chk(pa >= 0 && pb > pa, "R10 oldest ready served first", pb, pa + 1);
        chk(da == 'h0C0C, "R10 data of first load", da, 'h0C0C);
    endtask

    initial begin
        idle(3);
        #0.5;
        t_reset();
        rst = 1'b0;
        idle(2);
        t_store_then_load();
        t_wait_and_bypass();
        t_same_cycle_capture();
        t_load_before_store();
        t_store_store();
        t_full();
        t_oldest_first();
        idle(4);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #400000;
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule